// File: doc/BRIEF.md
# Channel Hit Trigger and Sticky Hit Register

This block gathers the discriminator outputs of a bank of detector channels. Each channel can be masked by its own inhibit bit. Every clock, the block produces three results from the channels that are not masked:

- a global trigger, which is the OR of all active channels;
- a multiplicity, which is the number of channels active at that moment;
- a sticky hit register with one bit per channel.

The readout controller uses the hit register to read out only the channels that were hit. The same register can be read over the slow-control path. Configuration arrives as parallel inputs.

The discriminator inputs are asynchronous to the clock, so each one passes through a synchronizer chain. All three results are taken from the synchronized, masked vector. The hit register has its own clear input, separate from the block reset. A freeze input lets the readout see a stable set of hits while the trigger keeps running.

Top module: `chan_hit_trigger`

## Requirements
- R1: While `rst_n` is low, `trig_out`, `mult_out` and `hit_reg` are all zero, whatever the discriminator inputs do.
- R2: `trig_out` is high exactly when at least one non-inhibited channel is active. A change on `disc_in` shows at `trig_out` on the third rising clock edge after it is applied (two synchronizer flops plus one output register).
- R3: A channel whose `inhibit` bit is 1 contributes to none of `trig_out`, `mult_out` or `hit_reg`. Bit i of `inhibit` controls bit i of `disc_in`.
- R4: `mult_out` equals the number of active, non-inhibited channels, with the same three-edge latency as R2. It reaches the full channel count (72 by default) without wrapping.
- R5: Hit bits are sticky. Bit i of `hit_reg` is set on the third edge after channel i goes active while not inhibited. The bit then stays set after the discriminator returns low, until it is cleared.
- R6: `hit_clr` is sampled on the rising edge and clears every bit of `hit_reg` on that edge. The clear has priority over new hits arriving on the same edge.
- R7: While `freeze` is high, `hit_reg` holds its value and accepts no new hits. `trig_out` and `mult_out` keep updating during the freeze.
- R8: A change on `inhibit` acts after the synchronizers. It therefore shows at `trig_out` and `mult_out` on the first rising edge after it is applied.
- R9: If a channel is still active when `hit_clr` is applied, its bit reads 0 after the clear edge. The bit is set again on the next edge that has no clear and no freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of all state |
| disc_in | input | 72 | Asynchronous discriminator outputs, one per channel |
| inhibit | input | 72 | Per-channel mask; 1 removes the channel |
| freeze | input | 1 | Holds the hit register for readout |
| hit_clr | input | 1 | Synchronous clear of the hit register |
| trig_out | output | 1 | Registered OR of active non-inhibited channels |
| mult_out | output | 7 | Registered count of active non-inhibited channels |
| hit_reg | output | 72 | Sticky latched hit flags |

## Verification
Results driven by `disc_in` (trigger, multiplicity and new hit bits) are due on the third rising edge after the inputs change. Results driven by `inhibit`, `freeze` and `hit_clr` are due on the first rising edge. The bench drives every input on a falling edge and advances exactly that many rising edges. It then samples at the following falling edge, so each check lands half a cycle after the register that produces the result has updated. The sweeps walk a single active channel across all positions, grow the number of active channels from 0 up to the maximum, and cover masking, freeze and clear against a channel that is still active.

// File: rtl/hit_trig_pkg.sv
package hit_trig_pkg;
   // width needed to count from 0 up to n inclusive
   function automatic int count_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/hit_sync_bank.sv
module hit_sync_bank #(
   parameter int WIDTH  = 72,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hit_sync_bank: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("hit_sync_bank: WIDTH must be positive");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/hit_popcount.sv
module hit_popcount #(
   parameter int WIDTH = 72,
   parameter int CNT_W = 7
) (
   input  logic [WIDTH-1:0] vec,
   output logic [CNT_W-1:0] count
);
   if ((1 << CNT_W) <= WIDTH) begin : g_bad_cnt
      $error("hit_popcount: CNT_W too narrow for WIDTH");
   end

   always_comb begin
      count = '0;
      for (int i = 0; i < WIDTH; i++) begin
         count = count + CNT_W'(vec[i]);
      end
   end
endmodule

// File: rtl/hit_latch.sv
module hit_latch #(
   parameter int WIDTH = 72
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             freeze,
   input  logic [WIDTH-1:0] hits,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] flags
);
   logic [WIDTH-1:0] flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flags_q <= '0;
      else if (clr)     flags_q <= '0;
      else if (!freeze) flags_q <= flags_q | hits;
   end

   assign flags = flags_q;

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (flags_q == '0)); // R6
   AST_BITS_STICK: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R5
   AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !clr) |=> (flags_q == $past(flags_q))); // R7
   AST_MASKED_NEVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((flags_q & ~$past(flags_q) & $past(mask)) == '0)); // R3
endmodule

// File: rtl/chan_hit_trigger.sv
module chan_hit_trigger
   import hit_trig_pkg::*;
#(
   parameter int NCH         = 72,
   parameter int SYNC_STAGES = 2,
   parameter int MULT_W      = count_width(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    disc_in,
   input  logic [NCH-1:0]    inhibit,
   input  logic              freeze,
   input  logic              hit_clr,
   output logic              trig_out,
   output logic [MULT_W-1:0] mult_out,
   output logic [NCH-1:0]    hit_reg
);
   localparam int MIN_W = count_width(NCH);

   if (MULT_W < MIN_W) begin : g_bad_mult
      $error("chan_hit_trigger: MULT_W cannot hold NCH");
   end

   logic [NCH-1:0]    disc_sync;
   logic [NCH-1:0]    active;
   logic [MULT_W-1:0] active_cnt;
   logic              trig_q;
   logic [MULT_W-1:0] mult_q;

   hit_sync_bank #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(disc_in), .sync_out(disc_sync)
   );

   assign active = disc_sync & ~inhibit;

   hit_popcount #(.WIDTH(NCH), .CNT_W(MULT_W)) u_count (
      .vec(active), .count(active_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q <= 1'b0;
         mult_q <= '0;
      end else begin
         trig_q <= |active;
         mult_q <= active_cnt;
      end
   end

   hit_latch #(.WIDTH(NCH)) u_latch (
      .clk(clk), .rst_n(rst_n), .clr(hit_clr), .freeze(freeze),
      .hits(active), .mask(inhibit), .flags(hit_reg)
   );

   assign trig_out = trig_q;
   assign mult_out = mult_q;

   AST_TRIG_AGREES_MULT: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out == (mult_out != '0)); // R2
   AST_MULT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      mult_out <= MULT_W'(NCH)); // R4
   AST_FULL_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (&inhibit) |=> (!trig_out && mult_out == '0)); // R3
endmodule

// File: tb/chan_hit_trigger_bench.sv
module chan_hit_trigger_bench;
   localparam int NCH = 72;
   localparam int MW  = 7;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] disc_in = '0;
   logic [NCH-1:0] inhibit = '0;
   logic           freeze = 1'b0;
   logic           hit_clr = 1'b0;
   logic           trig_out;
   logic [MW-1:0]  mult_out;
   logic [NCH-1:0] hit_reg;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   chan_hit_trigger #(.NCH(NCH), .SYNC_STAGES(2), .MULT_W(MW)) u_chan_hit_trigger (
      .clk(clk), .rst_n(rst_n), .disc_in(disc_in), .inhibit(inhibit),
      .freeze(freeze), .hit_clr(hit_clr), .trig_out(trig_out),
      .mult_out(mult_out), .hit_reg(hit_reg)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [NCH-1:0] ones_below(input int k);
      logic [NCH-1:0] v = '0;
      for (int i = 0; i < k; i++) v[i] = 1'b1;
      return v;
   endfunction

   initial begin
      logic [NCH-1:0] pat;
      logic [NCH-1:0] alt;
      // R1: reset state with all channels firing
      disc_in = '1;
      step(5);
      chk("R1 trig", NCH'(trig_out), '0);
      chk("R1 mult", NCH'(mult_out), '0);
      chk("R1 hits", hit_reg, '0);
      disc_in = '0;
      step(3);
      rst_n = 1'b1;
      step(3);

      // R2 R4 R5: walking single channel, sticky accumulation
      for (int ch = 0; ch < NCH; ch++) begin
         disc_in = '0;
         disc_in[ch] = 1'b1;
         step(2);
         chk("R2 latency", NCH'(trig_out), '0);
         step(1);
         chk("R2 trig", NCH'(trig_out), NCH'(1));
         chk("R4 mult one", NCH'(mult_out), NCH'(1));
         chk("R5 sticky", hit_reg, ones_below(ch + 1));
         disc_in = '0;
         step(3);
         chk("R2 trig low", NCH'(trig_out), '0);
      end

      // R6: clear
      hit_clr = 1'b1;
      step(1);
      hit_clr = 1'b0;
      chk("R6 clear", hit_reg, '0);

      // R4: count sweep 0..NCH
      for (int k = 0; k <= NCH; k++) begin
         disc_in = ones_below(k);
         step(3);
         chk("R4 count", NCH'(mult_out), NCH'(k));
         chk("R2 or", NCH'(trig_out), NCH'(k != 0));
      end

      // R3: mask alternate channels
      disc_in = '0;
      step(3);
      hit_clr = 1'b1;
      step(1);
      hit_clr = 1'b0;
      alt = '0;
      for (int i = 0; i < NCH; i += 2) alt[i] = 1'b1;
      inhibit = alt;
      disc_in = '1;
      step(3);
      chk("R3 mult", NCH'(mult_out), NCH'(NCH / 2));
      chk("R3 hits", hit_reg, ~alt);
      // R8: full mask acts on next edge
      inhibit = '1;
      step(1);
      chk("R8 trig off", NCH'(trig_out), '0);
      chk("R8 mult off", NCH'(mult_out), '0);
      chk("R3 hits unchanged", hit_reg, ~alt);
      inhibit = '0;
      step(1);
      chk("R8 mult back", NCH'(mult_out), NCH'(NCH));

      // R7: freeze
      disc_in = '0;
      step(3);
      hit_clr = 1'b1;
      step(1);
      hit_clr = 1'b0;
      pat = '0;
      pat[3] = 1'b1; pat[40] = 1'b1; pat[71] = 1'b1;
      freeze = 1'b1;
      disc_in = pat;
      step(3);
      chk("R7 frozen", hit_reg, '0);
      chk("R7 trig runs", NCH'(trig_out), NCH'(1));
      chk("R7 mult runs", NCH'(mult_out), NCH'(3));
      freeze = 1'b0;
      step(1);
      chk("R7 release", hit_reg, pat);

      // R9 R6: clear while still active
      hit_clr = 1'b1;
      step(1);
      hit_clr = 1'b0;
      chk("R9 cleared", hit_reg, '0);
      step(1);
      chk("R9 reset", hit_reg, pat);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule